// File: doc/BRIEF.md
# Reference Dwell Qualifier

This block decides whether one timing reference may be used, starting from the raw pass/fail flag that a period monitor produces. A reference that has been faulted is not accepted the moment its fault flag drops. It must first stay clean for a programmed number of milliseconds. In the other direction, a reference that stays faulted for a second programmed number of milliseconds raises a one-cycle request. A profile-selection engine outside this block uses that request to try assigning the input to a new profile.

Both dwell times are counted in whole milliseconds, using an external 1 ms tick. A timeout of zero switches the matching timer off. With the validation dwell switched off, software has to qualify a clean reference by hand, using a force-timeout pulse. Two further override inputs, force-valid and force-invalid, bypass the qualification for troubleshooting. Force-invalid wins when both are set.

Top module: `refq_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `ref_valid` is 0 and `redetect_req` is 0, provided no override input is set.
- R2: With `valid_ms` = N > 0 and `raw_fault` low, the qualified state rises at the clock edge that samples the Nth `ms_tick` of the clean interval, and not before.
- R3: A cycle with `raw_fault` high clears the qualified state at the next edge and restarts the validation count from zero.
- R4: With `valid_ms` = 0, the timer never validates the reference. A `force_timeout` pulse sampled while `raw_fault` is low sets the qualified state at that edge. The same pulse sampled while `raw_fault` is high is ignored.
- R5: A `force_timeout` pulse while the reference is clean also validates at once when `valid_ms` is nonzero and the count has not yet expired.
- R6: With `auto_prof_en` = 1 and `redetect_ms` = M > 0, `redetect_req` goes high for exactly one cycle after the edge that samples the Mth `ms_tick` of a continuous faulted interval. It fires only once in that interval.
- R7: Any cycle with `raw_fault` low restarts the redetect count from zero.
- R8: No redetect request is issued while `redetect_ms` = 0 or while `auto_prof_en` = 0.
- R9: `ref_valid` follows the override inputs combinationally. `force_invalid` = 1 gives 0. Otherwise `force_valid` = 1 gives 1. Otherwise `ref_valid` shows the qualified state. The overrides leave the qualified state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse for each elapsed millisecond |
| raw_fault | input | 1 | Fault flag from the period monitor, 1 = out of tolerance |
| valid_ms | input | 16 | Validation dwell in ms, 0 = timer off |
| redetect_ms | input | 16 | Redetect dwell in ms, 0 = timer off |
| auto_prof_en | input | 1 | Automatic profile selection enabled |
| force_timeout | input | 1 | One-cycle pulse that ends the validation dwell at once |
| force_valid | input | 1 | Override: report valid |
| force_invalid | input | 1 | Override: report invalid, wins over force_valid |
| ref_valid | output | 1 | Final validity of the reference |
| redetect_req | output | 1 | One-cycle request to reassign the reference |

## Verification
The validation dwell is tried with three clean intervals: an unbroken one, one cut by a single faulted cycle, and one with the timer off. Together these separate correct counting from an off-by-one, from a count that does not restart, and from a zero limit being treated as an expired count. The redetect side is run through an unbroken faulted interval that lasts well past the limit, to show a single pulse. It is then run through a faulted interval broken by a clean cycle, and with each of its two disabling conditions. Each override is applied both against a qualified state of 0 and against one of 1, and is then released. This shows that the overrides act only on the output and that their priority is as stated.

// File: rtl/refq_pkg.sv
package refq_pkg;

    parameter int REFQ_MS_W = 16;

    typedef struct packed {
        logic force_timeout;
        logic force_valid;
        logic force_invalid;
    } refq_ovr_t;

    function automatic logic refq_resolve(input refq_ovr_t ovr, input logic qualified);
        if (ovr.force_invalid)
            return 1'b0;
        else if (ovr.force_valid)
            return 1'b1;
        else
            return qualified;
    endfunction

endpackage

// File: rtl/refq_dwell_timer.sv
module refq_dwell_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt;
    logic             spent;
    logic             armed;
    logic [EXT_W-1:0] next_cnt;

    assign armed    = run && !spent && (limit != '0);
    assign next_cnt = {1'b0, cnt} + EXT_W'(1);
    assign fire     = armed && tick && (next_cnt >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            spent <= 1'b0;
        end else if (fire) begin
            spent <= 1'b1;
        end else if (armed && tick) begin
            cnt <= next_cnt[CNT_W-1:0];
        end
    end

    // R6: a dwell fires at most once before its run interval ends
    p_single_fire_r6: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

endmodule

// File: rtl/refq_override.sv
module refq_override
    import refq_pkg::*;
(
    input  refq_ovr_t ovr,
    input  logic      qualified,
    output logic      valid_o
);
    always_comb begin
        valid_o = refq_resolve(ovr, qualified);
    end
endmodule

// File: rtl/refq_top.sv
module refq_top
    import refq_pkg::*;
#(
    parameter int MS_W = REFQ_MS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ms_tick,
    input  logic            raw_fault,
    input  logic [MS_W-1:0] valid_ms,
    input  logic [MS_W-1:0] redetect_ms,
    input  logic            auto_prof_en,
    input  logic            force_timeout,
    input  logic            force_valid,
    input  logic            force_invalid,
    output logic            ref_valid,
    output logic            redetect_req
);
    refq_ovr_t ovr;
    logic      q_valid;
    logic      val_fire;
    logic      red_fire;
    logic      red_run;

    assign ovr     = '{force_timeout: force_timeout,
                       force_valid:   force_valid,
                       force_invalid: force_invalid};
    assign red_run = raw_fault && auto_prof_en;

    refq_dwell_timer #(.CNT_W(MS_W)) u_val_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (ms_tick),
        .run   (!raw_fault),
        .limit (valid_ms),
        .fire  (val_fire)
    );

    refq_dwell_timer #(.CNT_W(MS_W)) u_red_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (ms_tick),
        .run   (red_run),
        .limit (redetect_ms),
        .fire  (red_fire)
    );

    always_ff @(posedge clk) begin
        if (rst)
            q_valid <= 1'b0;
        else if (raw_fault)
            q_valid <= 1'b0;
        else if (val_fire || ovr.force_timeout)
            q_valid <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            redetect_req <= 1'b0;
        else
            redetect_req <= red_fire;
    end

    refq_override u_ovr (
        .ovr       (ovr),
        .qualified (q_valid),
        .valid_o   (ref_valid)
    );

    // R2: qualification only rises after a clean cycle
    p_rise_clean_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(q_valid) |-> !$past(raw_fault));

    // R3: a faulted cycle removes qualification
    p_fault_drop_r3: assert property (@(posedge clk) disable iff (rst)
        raw_fault |=> !q_valid);

    // R4: with the timer off only the manual pulse qualifies
    p_zero_manual_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(q_valid) && ($past(valid_ms) == '0)) |-> $past(force_timeout));

    // R6: request lasts a single cycle
    p_req_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        redetect_req |=> !redetect_req);

    // R8: request needs an enabled redetect dwell on a faulted reference
    p_req_cause_r8: assert property (@(posedge clk) disable iff (rst)
        redetect_req |-> $past(raw_fault && auto_prof_en && (redetect_ms != '0)));

endmodule

// File: tb/refq_top_tb_top.sv
module refq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        ms_tick;
    logic        raw_fault;
    logic [15:0] valid_ms;
    logic [15:0] redetect_ms;
    logic        auto_prof_en;
    logic        force_timeout;
    logic        force_valid;
    logic        force_invalid;
    logic        ref_valid;
    logic        redetect_req;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    refq_top dut_i (
        .clk           (clk),
        .rst           (rst),
        .ms_tick       (ms_tick),
        .raw_fault     (raw_fault),
        .valid_ms      (valid_ms),
        .redetect_ms   (redetect_ms),
        .auto_prof_en  (auto_prof_en),
        .force_timeout (force_timeout),
        .force_valid   (force_valid),
        .force_invalid (force_invalid),
        .ref_valid     (ref_valid),
        .redetect_req  (redetect_req)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // called at a falling edge; applies inputs across one rising edge
    task automatic step(input logic tk, input logic flt);
        ms_tick   = tk;
        raw_fault = flt;
        @(negedge clk);
        ms_tick       = 1'b0;
        force_timeout = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; ms_tick = 0; raw_fault = 0; valid_ms = 16'd4; redetect_ms = 16'd3;
        auto_prof_en = 0; force_timeout = 0; force_valid = 0; force_invalid = 0;
        repeat (3) @(negedge clk);
        chk(ref_valid, 1'b0, "R1", "valid in reset");
        chk(redetect_req, 1'b0, "R1", "req in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(ref_valid, 1'b0, "R1", "valid after reset");
        chk(redetect_req, 1'b0, "R1", "req after reset");
    endtask

    task automatic t_validate();
        valid_ms = 16'd5;
        step(1, 1);
        for (int i = 1; i <= 4; i++) begin
            step(1, 0);
            chk(ref_valid, 1'b0, "R2", $sformatf("before tick 5, tick %0d", i));
        end
        step(0, 0);
        chk(ref_valid, 1'b0, "R2", "idle cycle does not count");
        step(1, 0);
        chk(ref_valid, 1'b1, "R2", "valid at tick 5");
    endtask

    task automatic t_fault_restart();
        valid_ms = 16'd4;
        step(0, 1);
        chk(ref_valid, 1'b0, "R3", "fault clears valid");
        repeat (3) step(1, 0);
        step(0, 1);
        chk(ref_valid, 1'b0, "R3", "still invalid after glitch");
        repeat (3) step(1, 0);
        chk(ref_valid, 1'b0, "R3", "count restarted from zero");
        step(1, 0);
        chk(ref_valid, 1'b1, "R3", "valid after full clean dwell");
    endtask

    task automatic t_zero_force();
        valid_ms = 16'd0;
        step(1, 1);
        repeat (10) step(1, 0);
        chk(ref_valid, 1'b0, "R4", "zero limit never validates");
        force_timeout = 1'b1;
        step(0, 1);
        step(1, 0);
        chk(ref_valid, 1'b0, "R4", "force during fault ignored");
        force_timeout = 1'b1;
        step(0, 0);
        chk(ref_valid, 1'b1, "R4", "force while clean validates");
    endtask

    task automatic t_force_shortcut();
        valid_ms = 16'd50;
        step(1, 1);
        repeat (2) step(1, 0);
        chk(ref_valid, 1'b0, "R5", "counting, not yet valid");
        force_timeout = 1'b1;
        step(0, 0);
        chk(ref_valid, 1'b1, "R5", "force shortcuts dwell");
    endtask

    task automatic t_redetect();
        auto_prof_en = 1'b1; redetect_ms = 16'd3;
        step(1, 0);
        step(1, 1);
        step(1, 1);
        chk(redetect_req, 1'b0, "R6", "no request before tick 3");
        step(1, 1);
        chk(redetect_req, 1'b1, "R6", "request after tick 3");
        step(1, 1);
        chk(redetect_req, 1'b0, "R6", "request is one cycle");
        begin
            logic seen = 1'b0;
            for (int i = 0; i < 8; i++) begin
                step(1, 1);
                if (redetect_req) seen = 1'b1;
            end
            chk(seen, 1'b0, "R6", "only once per faulted interval");
        end
    endtask

    task automatic t_redetect_restart();
        auto_prof_en = 1'b1; redetect_ms = 16'd3;
        step(1, 0);
        step(1, 1);
        step(1, 1);
        step(1, 0);
        chk(redetect_req, 1'b0, "R7", "clean cycle breaks count");
        step(1, 1);
        step(1, 1);
        chk(redetect_req, 1'b0, "R7", "count restarted");
        step(1, 1);
        chk(redetect_req, 1'b1, "R7", "fires after full faulted dwell");
        step(0, 0);
    endtask

    task automatic t_redetect_disabled();
        logic seen;
        redetect_ms = 16'd0; auto_prof_en = 1'b1;
        step(1, 0);
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            step(1, 1);
            if (redetect_req) seen = 1'b1;
        end
        chk(seen, 1'b0, "R8", "zero limit gives no request");
        redetect_ms = 16'd3; auto_prof_en = 1'b0;
        step(1, 0);
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            step(1, 1);
            if (redetect_req) seen = 1'b1;
        end
        chk(seen, 1'b0, "R8", "auto disabled gives no request");
    endtask

    task automatic t_overrides();
        valid_ms = 16'd2;
        step(0, 1);
        force_valid = 1'b1; #1;
        chk(ref_valid, 1'b1, "R9", "force valid over invalid");
        force_invalid = 1'b1; #1;
        chk(ref_valid, 1'b0, "R9", "force invalid wins");
        force_valid = 1'b0;
        step(1, 0);
        step(1, 0);
        chk(ref_valid, 1'b0, "R9", "force invalid masks valid");
        force_invalid = 1'b0; #1;
        chk(ref_valid, 1'b1, "R9", "qualified state kept under override");
        force_valid = 1'b1; #1;
        force_valid = 1'b0; #1;
        chk(ref_valid, 1'b1, "R9", "release restores qualified state");
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_validate();
        t_fault_restart();
        t_zero_force();
        t_force_shortcut();
        t_redetect();
        t_redetect_restart();
        t_redetect_disabled();
        t_overrides();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule